// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

The block times a known sync character (0x55) on an asynchronous serial input and leaves the bit-rate generator period in a result register. After a permitted arm request, it clears its measurement counter and restarts its prescaler. It then waits for the falling edge that opens the start bit. Counting starts at the next rising edge of the line and stops at the fifth rising edge, which falls on the stop bit.

The counter runs on a prescaled tick that is one-eighth of the normal generator rate for the selected mode. The interval it measures is eight bit times long and holds four low/high pairs, so uneven high and low widths cancel. Because of the one-eighth rate, the accumulated count equals the generator period directly and needs no division. When the measurement ends, the block drops its busy indication and raises a completion flag. The flag stays up until the host acknowledges it. The host keeps the normal receiver idle while the block is busy.

Top module: `autobaud_detector`

## Requirements
- R1: After reset, busy_o, done_o and ovf_o are 0 and divisor_o is 0.
- R2: An arm_i pulse is accepted only while async_mode_i is 1 and wake_en_i is 0. Otherwise it is ignored: busy_o stays 0 and divisor_o and done_o keep their values.
- R3: An accepted arm_i sets busy_o and clears divisor_o, done_o and ovf_o on the next cycle. It also restarts a measurement that is already in progress.
- R4: The counter advances once per prescaler tick from the first rising edge of rx_i after a falling edge to the fifth rising edge. For a 0x55 frame sent LSB first with bit time T clocks, where 8T is a multiple of the tick period P, the result is 8T/P.
- R5: The tick period is selected by mode_i = {wide, high_speed}: 00 gives 512 clocks, 01 gives 256, 10 gives 128 and 11 gives 32. mode_i is captured at arm, and later changes have no effect on the running measurement.
- R6: Three clock edges after rx_i rises for the fifth time, busy_o is 0 and done_o is 1. After two edges, done_o is still 0.
- R7: If a tick arrives while the counter holds its maximum (2^CNT_W - 1), the counter stays at the maximum and ovf_o is set.
- R8: done_o stays at 1 until a cycle with rd_ack_i = 1, and is 0 on the cycle after that.
- R9: If async_mode_i drops or wake_en_i rises while busy, the measurement is abandoned: busy_o falls on the next cycle and done_o is not set.
- R10: While busy_o is 0 and no arm is presented, divisor_o does not change, whatever rx_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| arm_i | input | 1 | One-cycle request to start a measurement |
| async_mode_i | input | 1 | 1 when the port runs in asynchronous mode |
| wake_en_i | input | 1 | 1 when wake-on-break is enabled; blocks detection |
| mode_i | input | 2 | {wide, high_speed} selection of the tick period |
| rd_ack_i | input | 1 | Host read acknowledge; clears done_o |
| divisor_o | output | CNT_W | Measured generator period |
| busy_o | output | 1 | Enable readback; 1 while a measurement is armed |
| done_o | output | 1 | Completion flag |
| ovf_o | output | 1 | Counter saturated during the measurement |

## Verification
A wrong edge count or a missed start detection shows up in two ways. Either busy_o never falls, or done_o rises one bit-pair early with a divisor short by a quarter of the expected value. Both are visible within three cycles of the fifth rising edge. A prescaler that is not realigned, or a mode that is not captured at arm, gives a divisor off by one or by a power of two at the next completion. A stale counter after re-arm shows as a nonzero divisor_o on the cycle after arm.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEEK_START,
    ST_SEEK_RISE,
    ST_MEASURE
  } abd_state_t;

  // Extra divide steps above the fastest tick for each {wide, high_speed} code
  function automatic logic [3:0] mode_shift(input logic [1:0] m);
    case (m)
      2'b00:   mode_shift = 4'd4;
      2'b01:   mode_shift = 4'd3;
      2'b10:   mode_shift = 4'd2;
      default: mode_shift = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], line_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
  assign fall_o = ~sh[STAGES-1] & sh[STAGES];

  // R4: an edge pulse lasts exactly one cycle
  a_r4_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/abd_prescaler.sv
module abd_prescaler #(
  parameter int BASE_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart_i,
  input  logic       run_i,
  input  logic [1:0] mode_i,
  output logic       tick_o
);
  import abd_pkg::*;
  localparam int PW = BASE_LOG2 + 5;

  logic [PW-1:0] pre;
  logic [PW-1:0] last;

  always_comb begin
    last = ({{(PW-1){1'b0}}, 1'b1} << (BASE_LOG2 + int'(mode_shift(mode_i)))) - 1'b1;
  end

  assign tick_o = run_i && (pre == last);

  always_ff @(posedge clk) begin
    if (rst || restart_i) pre <= '0;
    else if (run_i)       pre <= tick_o ? '0 : pre + 1'b1;
  end

  // R5: after a tick the divider starts a fresh period
  a_r5_tick_wraps: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !restart_i) |=> (pre == '0));
endmodule

// File: rtl/abd_counter.sv
module abd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (inc_i) begin
      if (cnt_o == MAXV) ovf_o <= 1'b1;
      else               cnt_o <= cnt_o + 1'b1;
    end
  end

  // R3: clear takes effect on the next cycle
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0 && !ovf_o));
  // R7: the count never wraps past its maximum
  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == MAXV && !clr_i) |=> (cnt_o == MAXV));
endmodule

// File: rtl/autobaud_detector.sv
module autobaud_detector #(
  parameter int CNT_W       = 16,
  parameter int BASE_LOG2   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int RISE_EDGES  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  input  logic             arm_i,
  input  logic             async_mode_i,
  input  logic             wake_en_i,
  input  logic [1:0]       mode_i,
  input  logic             rd_ack_i,
  output logic [CNT_W-1:0] divisor_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovf_o
);
  import abd_pkg::*;
  localparam int RW = $clog2(RISE_EDGES + 1);
  localparam logic [RW-1:0] LAST_RISE = RW'(RISE_EDGES - 1);

  abd_state_t state;
  logic [1:0] mode_q;
  logic [RW-1:0] rises;
  logic rise, fall, tick, allowed, arm_ok, restart, measuring, cnt_inc;

  assign allowed   = async_mode_i & ~wake_en_i;
  assign arm_ok    = arm_i & allowed;
  assign measuring = (state == ST_MEASURE);
  assign restart   = arm_ok | ((state == ST_SEEK_RISE) & rise);
  assign cnt_inc   = tick & measuring & ~arm_ok;
  assign busy_o    = (state != ST_IDLE);

  abd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_i(rx_i), .rise_o(rise), .fall_o(fall)
  );

  abd_prescaler #(.BASE_LOG2(BASE_LOG2)) u_pre (
    .clk(clk), .rst(rst), .restart_i(restart), .run_i(measuring),
    .mode_i(mode_q), .tick_o(tick)
  );

  abd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(arm_ok), .inc_i(cnt_inc),
    .cnt_o(divisor_o), .ovf_o(ovf_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      mode_q <= 2'b00;
      rises  <= '0;
      done_o <= 1'b0;
    end else if (arm_ok) begin
      state  <= ST_SEEK_START;
      mode_q <= mode_i;
      rises  <= '0;
      done_o <= 1'b0;
    end else begin
      if (rd_ack_i) done_o <= 1'b0;
      if (busy_o && !allowed) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_SEEK_START: if (fall) state <= ST_SEEK_RISE;
          ST_SEEK_RISE: if (rise) begin
            state <= ST_MEASURE;
            rises <= RW'(1);
          end
          ST_MEASURE: if (rise) begin
            if (rises == LAST_RISE) begin
              state  <= ST_IDLE;
              done_o <= 1'b1;
            end else begin
              rises <= rises + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: a blocked arm leaves the block idle
  a_r2_blocked_arm: assert property (@(posedge clk) disable iff (rst)
    (arm_i && !allowed && !busy_o) |=> !busy_o);
  // R6: completion and busy never overlap at the rising flag
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> !busy_o);
  // R8: the flag holds until acknowledged or re-armed
  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done_o && !rd_ack_i && !arm_i) |=> done_o);
  // R9: losing permission abandons the measurement
  a_r9_abort: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !allowed) |=> (!busy_o && !$rose(done_o)));
  // R10: the result is frozen while idle
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !arm_i) |=> $stable(divisor_o));
endmodule

// File: tb/test_autobaud_detector.sv
module test_autobaud_detector;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx = 1'b1, arm = 1'b0, async_mode = 1'b1, wake_en = 1'b0, rd_ack = 1'b0;
  logic [1:0] mode = 2'b11;
  logic [CW-1:0] divisor;
  logic busy, done, ovf;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct { logic [CW-1:0] div; logic ovf; string req; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  autobaud_detector #(.CNT_W(CW)) i_autobaud_detector (
    .clk(clk), .rst(rst), .rx_i(rx), .arm_i(arm), .async_mode_i(async_mode),
    .wake_en_i(wake_en), .mode_i(mode), .rd_ack_i(rd_ack),
    .divisor_o(divisor), .busy_o(busy), .done_o(done), .ovf_o(ovf)
  );

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm(input logic [1:0] m);
    mode = m;
    arm = 1'b1;
    cyc(1);
    arm = 1'b0;
  endtask

  // Drives start bit and 0x55 LSB first; leaves the line at the stop level
  task automatic send_frame(input int t);
    rx = 1'b0;
    cyc(t);
    for (int b = 0; b < 8; b++) begin
      rx = (b % 2 == 0);
      cyc(t);
    end
    rx = 1'b1;
  endtask

  task automatic expect_result(input int d, input logic o, input string req);
    exp_t e;
    e.div = CW'(d);
    e.ovf = o;
    e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: pops one expected result per rising completion flag
  logic done_q = 1'b0;
  always @(negedge clk) begin
    if (!rst && done && !done_q) begin
      if (sb.size() == 0) begin
        chk("R4 unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.req, " divisor"}, int'(divisor), int'(e.div));
        chk({e.req, " ovf"}, int'(ovf), int'(e.ovf));
      end
    end
    done_q = done;
  end

  task automatic ack();
    rd_ack = 1'b1;
    cyc(1);
    rd_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 divisor", int'(divisor), 0);

    // R2 arm blocked outside async mode or with wake enabled
    async_mode = 1'b0;
    do_arm(2'b11);
    chk("R2 busy async off", busy, 0);
    async_mode = 1'b1;
    wake_en = 1'b1;
    do_arm(2'b11);
    chk("R2 busy wake on", busy, 0);
    wake_en = 1'b0;

    // R3/R4/R6 mode 11, tick 32, T=112 -> 28
    do_arm(2'b11);
    chk("R3 busy after arm", busy, 1);
    chk("R3 divisor cleared", int'(divisor), 0);
    expect_result(28, 1'b0, "R4 mode11");
    send_frame(112);
    @(posedge clk); @(posedge clk); #1;
    chk("R6 done not yet", done, 0);
    @(posedge clk); #1;
    chk("R6 done set", done, 1);
    chk("R6 busy cleared", busy, 0);
    cyc(20);
    // R8 flag holds, R10 result frozen against line activity
    rx = 1'b0; cyc(30); rx = 1'b1; cyc(30);
    chk("R8 done holds", done, 1);
    chk("R10 divisor frozen", int'(divisor), 28);
    ack();
    chk("R8 done cleared", done, 0);
    cyc(10);

    // R2 blocked arm keeps the previous result
    async_mode = 1'b0;
    do_arm(2'b00);
    chk("R2 divisor kept", int'(divisor), 28);
    async_mode = 1'b1;

    // R5 mode 10 (tick 128), mode changed after arm must not matter
    do_arm(2'b10);
    mode = 2'b11;
    expect_result(20, 1'b0, "R5 mode10 latched");
    send_frame(320);
    cyc(10); ack(); cyc(10);

    // R5 mode 01 (tick 256), T=320 -> 10
    do_arm(2'b01);
    expect_result(10, 1'b0, "R5 mode01");
    send_frame(320);
    cyc(10); ack(); cyc(10);

    // R5 mode 00 (tick 512), T=576 -> 9
    do_arm(2'b00);
    expect_result(9, 1'b0, "R5 mode00");
    send_frame(576);
    cyc(10); ack(); cyc(10);

    // R7 saturation: T=4200, 33600/32 = 1050 > 1023
    do_arm(2'b11);
    expect_result(1023, 1'b1, "R7 saturate");
    send_frame(4200);
    cyc(10); ack(); cyc(10);

    // R9 abort during measurement
    do_arm(2'b11);
    rx = 1'b0; cyc(100); rx = 1'b1; cyc(100);
    async_mode = 1'b0;
    cyc(1);
    chk("R9 busy after abort", busy, 0);
    async_mode = 1'b1;
    for (int b = 0; b < 8; b++) begin
      rx = (b % 2 == 1);
      cyc(100);
    end
    rx = 1'b1;
    cyc(10);
    chk("R9 no completion", done, 0);

    // R3 re-arm restarts an ongoing measurement
    do_arm(2'b11);
    rx = 1'b0; cyc(112); rx = 1'b1; cyc(112);
    rx = 1'b0; cyc(112); rx = 1'b1; cyc(50);
    do_arm(2'b11);
    chk("R3 re-arm busy", busy, 1);
    chk("R3 re-arm divisor cleared", int'(divisor), 0);
    cyc(50);
    expect_result(20, 1'b0, "R3 restart result");
    send_frame(80);
    cyc(10);
    chk("R4 scoreboard drained", sb.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule